// File: doc/BRIEF.md
# Dual-Channel Programmable Base-Clock Divider

This block derives two slower timing references from one base clock: one for the processor and internal bus, and one for the peripheral bus. Each channel has a 4-bit divide code, and both codes sit in one 16-bit control word. A code value N selects division by N+1, so each channel can divide by any ratio from 1 to 16. The two channels are independent of each other.

Each channel produces a single-cycle enable pulse once per output period, and a clock-style level that is high for the first part of the period. The control word can be written and read at any time. A channel picks up a new ratio only at the end of its current output period, so an output period is never cut short or stretched by a write. The block does not select the source clock, does not model the PLL, and does not check frequency limits.

Top module: `dual_clk_div`

## Requirements
- R1: The processor channel's code is held in control-word bits 15:12, and the peripheral channel's code in bits 11:8. Both fields can be written and read back; read data shows the stored word from the cycle after a write.
- R2: If a channel's active code is N, its enable output is high for one base cycle in every N+1 base cycles.
- R3: If the active code is 0, the channel's enable output is high on every base cycle.
- R4: After reset, both codes are 0, read data is 0, and both enables are high on every cycle.
- R5: A new code takes effect in the output period after the one in which it was written. The period in progress finishes with the old ratio. This also holds when the write falls in the last cycle of a period.
- R6: A write that leaves one channel's code unchanged does not disturb that channel's enable or clock-style timing.
- R7: Bits 7:0 of the control word always read as zero, and values written to them have no effect.
- R8: For an active code N, the clock-style output is high for the first floor(N/2)+1 cycles of each period and low for the rest. Odd codes therefore give 50% duty. For code 0 the output stays high.
- R9: The enable pulse marks the last cycle of a period, and the clock-style output is high in the cycle that follows the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Base clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Control-word write strobe |
| wr_data_i | input | 16 | Control-word write data |
| rd_data_o | output | 16 | Control-word read data |
| cpu_en_o | output | 1 | Processor/bus channel enable pulse |
| per_en_o | output | 1 | Peripheral channel enable pulse |
| cpu_clk_o | output | 1 | Processor/bus channel clock-style level |
| per_clk_o | output | 1 | Peripheral channel clock-style level |

## Verification
The hardest case to reach is a write that lands in the last cycle of a long period. In that cycle the counter wraps and the control word updates on the same edge, so the incoming code must take effect immediately and not one period late. The bench sets divide-by-16, waits until the enable is seen high, and writes in that same cycle. It also writes at random offsets within periods of random length. A behavioural model compares every output on every clock.

// File: rtl/dual_clk_div_pkg.sv
package dual_clk_div_pkg;
  localparam int REG_W  = 16;
  localparam int CODE_W = 4;
  localparam int NUM_CH = 2;
  localparam int FLD_W  = NUM_CH * CODE_W;
  localparam int RSV_W  = REG_W - FLD_W;

  // channel 0 occupies the top field, channel 1 the next one down
  function automatic int field_lsb(input int ch);
    return REG_W - CODE_W * (ch + 1);
  endfunction
endpackage

// File: rtl/dual_clk_div_regs.sv
module dual_clk_div_regs
  import dual_clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic [FLD_W-1:0] code_nxt_o
);
  logic [FLD_W-1:0] fld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      fld_q <= '0;
    else if (wr_en_i) fld_q <= wr_data_i[REG_W-1 -: FLD_W];
  end

  // bypass so a write in a wrap cycle is seen by the channel
  assign code_nxt_o = wr_en_i ? wr_data_i[REG_W-1 -: FLD_W] : fld_q;
  assign rd_data_o  = {fld_q, {RSV_W{1'b0}}};
endmodule

// File: rtl/dual_clk_div_chan.sv
module dual_clk_div_chan #(
  parameter int CODE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_nxt_i,
  output logic              en_o,
  output logic              clk_o
);
  logic [CODE_W-1:0] cnt_q, act_q;
  logic              wrap;

  assign wrap = (cnt_q == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
      act_q <= code_nxt_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign en_o  = wrap;
  assign clk_o = (cnt_q <= (act_q >> 1));
endmodule

// File: rtl/dual_clk_div.sv
module dual_clk_div
  import dual_clk_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             cpu_en_o,
  output logic             per_en_o,
  output logic             cpu_clk_o,
  output logic             per_clk_o
);
  logic [FLD_W-1:0]  code_nxt;
  logic [NUM_CH-1:0] en, dclk;

  dual_clk_div_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .code_nxt_o(code_nxt)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    localparam int Lsb = field_lsb(ch) - RSV_W;
    dual_clk_div_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .code_nxt_i(code_nxt[Lsb +: CODE_W]),
      .en_o      (en[ch]),
      .clk_o     (dclk[ch])
    );
  end

  assign cpu_en_o  = en[0];
  assign per_en_o  = en[1];
  assign cpu_clk_o = dclk[0];
  assign per_clk_o = dclk[1];
endmodule

// File: rtl/dual_clk_div_chk.sv
module dual_clk_div_chk
  import dual_clk_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             cpu_en_o,
  input logic             per_en_o,
  input logic             cpu_clk_o,
  input logic             per_clk_o
);
  // R7
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[RSV_W-1:0] == '0);

  // R1
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o[REG_W-1 -: FLD_W] == $past(wr_data_i[REG_W-1 -: FLD_W]));

  // R9
  cpu_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_en_o |=> cpu_clk_o);

  // R9
  per_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_en_o |=> per_clk_o);

  // R8
  cpu_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_clk_o) |-> $past(cpu_en_o));

  // R8
  per_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(per_clk_o) |-> $past(per_en_o));
endmodule

bind dual_clk_div dual_clk_div_chk u_chk (.*);

// File: tb/dual_clk_div_bench.sv
module dual_clk_div_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [15:0] wr_data_i = '0;
  logic [15:0] rd_data_o;
  logic        cpu_en_o, per_en_o, cpu_clk_o, per_clk_o;

  int checks = 0;
  int errors = 0;

  // model: index 0 processor channel, 1 peripheral channel
  int stored[2];
  int active[2];
  int pos[2];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dual_clk_div u_dual_clk_div (.*);

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin stored[c] = 0; active[c] = 0; pos[c] = 0; end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int wf;
        wf = (c == 0) ? int'(wr_data_i[15:12]) : int'(wr_data_i[11:8]);
        if (pos[c] == active[c]) begin
          pos[c] = 0;
          active[c] = wr_en_i ? wf : stored[c];
        end else begin
          pos[c] = pos[c] + 1;
        end
        if (wr_en_i) stored[c] = wf;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // high phase length is ceil((N+1)/2) cycles from the start of a period
  function automatic int exp_clk(input int c);
    return (2 * pos[c] < active[c] + 1) ? 1 : 0;
  endfunction

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R1/R7 read data", int'(rd_data_o), (stored[0] << 12) | (stored[1] << 8));
      chk("R2/R3/R5 cpu enable", int'(cpu_en_o), (pos[0] == active[0]) ? 1 : 0);
      chk("R2/R5/R6 per enable", int'(per_en_o), (pos[1] == active[1]) ? 1 : 0);
      chk("R8/R9 cpu clock", int'(cpu_clk_o), exp_clk(0));
      chk("R6/R8 per clock", int'(per_clk_o), exp_clk(1));
    end
  end

  task automatic write_word(input logic [15:0] d);
    wr_en_i = 1'b1;
    wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
    wr_data_i = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    // R4: reset values seen while still in reset
    chk("R4 reset read", int'(rd_data_o), 0);
    chk("R4 reset cpu enable", int'(cpu_en_o), 1);
    chk("R4 reset per enable", int'(per_en_o), 1);
    rst_ni = 1'b1;
    idle(8);
    // R3: undivided after reset
    chk("R3 cpu enable every cycle", int'(cpu_en_o), 1);

    write_word(16'h3500);
    idle(60);
    // R6: only the peripheral code changes
    write_word(16'h3A00);
    idle(70);
    // R7: reserved bits written with ones
    write_word(16'hFFFF);
    chk("R7 reserved read zero", int'(rd_data_o[7:0]), 0);
    idle(50);
    // R5: write in the final cycle of a divide-by-16 period
    while (!cpu_en_o) @(negedge clk_i);
    write_word(16'h2100);
    idle(40);
    // R5: write in the middle of a long period
    write_word(16'hF000);
    idle(7);
    write_word(16'h4700);
    idle(60);
    for (int i = 0; i < 40; i++) begin
      write_word(16'($urandom()));
      idle(int'($urandom_range(0, 40)));
    end
    idle(40);
    // R8: odd code gives equal high and low phases
    write_word(16'h5500);
    idle(40);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule